// File: doc/BRIEF.md
# Dithered PWM Control-Voltage Generator

This block turns a 16-bit control word into a single PWM pin whose long-run average duty resolves all 16 bits, even though each PWM period only has 256 clock slots. A free-running 8-bit counter sets a period of 256 clocks (about 39 kHz at a 10 MHz clock). The upper byte of the control word sets the whole-slot high time of a period. The lower byte is a fraction: it is summed into an 8-bit accumulator once per period. Whenever that sum wraps, the next period is one slot longer. Over 256 periods the extra slots add up to exactly the lower byte.

A second channel shares the same counter and drives an analog panel meter. It shows a signed error code as duty: the most negative code gives 0%, zero gives 50%, and the most positive code gives 255/256. Until an external "timing reference seen" flag is raised, the meter stays at the 50% centre position whatever code is applied. Both channels load a new high-time level only at the boundary between periods, so a period is never cut short or stretched partway through. The RC filtering that follows the pins is outside the block.

Top module: `dither_pwm_dac`

## Requirements
- R1: After a synchronous reset the counter restarts at 0. The first period then has the control pin low for all 256 clocks and the meter pin high for exactly 128 clocks.
- R2: In every period each pin is high for one run of clocks starting at count 0 and low for the rest of the period, never high again after going low.
- R3: At the last clock of each period (count 255) the lower byte of the control word is added into an 8-bit accumulator. The next period's high time is the upper byte (bits 15:8), plus one if that addition carried out of 8 bits.
- R4: An upper byte of 0xFF together with a carry gives a period that is high for all 256 clocks.
- R5: A change of the control word partway through a period does not alter that period's high time. Only the value present at count 255 shapes the next period.
- R6: For a control word held constant for 256 consecutive periods, the total high time over those periods is 256 × upper byte + lower byte clocks.
- R7: While the reference-seen flag is 1, the meter high time of the next period is the 8-bit two's-complement error code plus 128 (so -128 gives 0, 0 gives 128, 127 gives 255).
- R8: While the reference-seen flag is 0, the meter high time is 128 clocks per period regardless of the error code.
- R9: Reset clears the accumulator. After a reset during operation, the carry sequence restarts from an empty accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (10 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| dac_word_i | input | 16 | Control word: bits 15:8 whole slots, bits 7:0 fraction |
| err_code_i | input | 8 | Signed error code shown on the meter |
| ref_seen_i | input | 1 | 1 once a timing reference has been received |
| dac_pwm_o | output | 1 | Dithered control PWM pin |
| meter_pwm_o | output | 1 | Meter PWM pin |

## Verification
Both pins are driven combinationally from the counter and a level register. A pin therefore reflects the current count within the same clock, while inputs affect the level only at the edge where the count is 255. A word or error code presented during period k shows up in period k+1 and not before. The bench changes inputs only at falling edges and samples each pin once per clock at the falling edge, 256 samples per period aligned to count 0. It compares the high count of each period against a prediction derived from the inputs held at the end of the previous period. For R6 it runs one lead-in period so that every summed period's level was loaded from the held word.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    // Default PWM resolution; the control word is twice as wide.
    localparam int PWM_W  = 8;
    localparam int WORD_W = 2 * PWM_W;
    localparam int N_CHAN = 2;

    // Channel slots of the shared slicer array.
    localparam int CH_DAC   = 0;
    localparam int CH_METER = 1;

    typedef enum logic {
        METER_CENTER = 1'b0,
        METER_TRACK  = 1'b1
    } meter_mode_e;

endpackage

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
    parameter int W = dpwm_pkg::PWM_W
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] LAST = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) cnt_o <= '0;
        else     cnt_o <= cnt_o + 1'b1;
    end

    assign wrap_o = (cnt_o == LAST);

    // R1: count returns to zero after the last slot
    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> (cnt_o == '0));

    // R1: count advances by one elsewhere
    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        !wrap_o |=> (cnt_o == $past(cnt_o) + 1'b1));

    // R1: reset restarts the period
    a_r1_reset: assert property (@(posedge clk)
        rst |=> (cnt_o == '0));

endmodule

// File: rtl/dpwm_dither.sv
module dpwm_dither #(
    parameter int W = dpwm_pkg::PWM_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wrap_i,
    input  logic [2*W-1:0] word_i,
    output logic [W:0]     level_o
);
    typedef struct packed {
        logic         carry;
        logic [W-1:0] frac;
    } sum_t;

    logic [W-1:0] acc_q;
    logic [W-1:0] whole;
    logic [W-1:0] part;
    sum_t         nxt;

    assign whole = word_i[2*W-1:W];
    assign part  = word_i[W-1:0];

    always_comb begin
        nxt = sum_t'({1'b0, acc_q} + {1'b0, part});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            level_o <= '0;
        end else if (wrap_i) begin
            acc_q   <= nxt.frac;
            level_o <= {1'b0, whole} + {{W{1'b0}}, nxt.carry};
        end
    end

    // R5: level changes only at a period boundary
    a_r5_dac_hold: assert property (@(posedge clk) disable iff (rst)
        !wrap_i |=> $stable(level_o));

    // R9: reset empties the accumulator and the level
    a_r9_clear: assert property (@(posedge clk)
        rst |=> (acc_q == '0) && (level_o == '0));

    // R3: a zero fraction never adds a slot
    a_r3_no_frac: assert property (@(posedge clk) disable iff (rst)
        (wrap_i && part == '0) |=> (level_o == {1'b0, $past(whole)}));

endmodule

// File: rtl/dpwm_meter_level.sv
module dpwm_meter_level #(
    parameter int W = dpwm_pkg::PWM_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wrap_i,
    input  logic signed [W-1:0] err_i,
    input  logic                seen_i,
    output logic [W:0]          level_o
);
    import dpwm_pkg::*;

    localparam logic [W:0]   MID  = (W+1)'(1) << (W-1);
    localparam logic [W-1:0] SIGN = W'(1) << (W-1);

    meter_mode_e  mode;
    logic [W-1:0] offset_code;
    logic [W:0]   target;

    assign mode        = seen_i ? METER_TRACK : METER_CENTER;
    assign offset_code = $unsigned(err_i) ^ SIGN;

    always_comb begin
        case (mode)
            METER_TRACK: target = {1'b0, offset_code};
            default:     target = MID;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         level_o <= MID;
        else if (wrap_i) level_o <= target;
    end

    // R8: centred while no reference has been seen
    a_r8_center: assert property (@(posedge clk) disable iff (rst)
        (wrap_i && !seen_i) |=> (level_o == MID));

    // R7: a zero error code lands on the centre
    a_r7_zero_mid: assert property (@(posedge clk) disable iff (rst)
        (wrap_i && seen_i && err_i == '0) |=> (level_o == MID));

    // R5: meter level changes only at a period boundary
    a_r5_meter_hold: assert property (@(posedge clk) disable iff (rst)
        !wrap_i |=> $stable(level_o));

endmodule

// File: rtl/dpwm_slicer.sv
module dpwm_slicer #(
    parameter int W = dpwm_pkg::PWM_W
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W:0]   level_i,
    output logic         pwm_o
);
    assign pwm_o = ({1'b0, cnt_i} < level_i);
endmodule

// File: rtl/dither_pwm_dac.sv
module dither_pwm_dac #(
    parameter int W = dpwm_pkg::PWM_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2*W-1:0]      dac_word_i,
    input  logic signed [W-1:0] err_code_i,
    input  logic                ref_seen_i,
    output logic                dac_pwm_o,
    output logic                meter_pwm_o
);
    import dpwm_pkg::*;

    logic [W-1:0] cnt;
    logic         wrap;
    logic [W:0]   level [N_CHAN];
    logic [N_CHAN-1:0] pins;

    dpwm_timebase #(.W(W)) u_timebase (
        .clk    (clk),
        .rst    (rst),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    dpwm_dither #(.W(W)) u_dither (
        .clk     (clk),
        .rst     (rst),
        .wrap_i  (wrap),
        .word_i  (dac_word_i),
        .level_o (level[CH_DAC])
    );

    dpwm_meter_level #(.W(W)) u_meter (
        .clk     (clk),
        .rst     (rst),
        .wrap_i  (wrap),
        .err_i   (err_code_i),
        .seen_i  (ref_seen_i),
        .level_o (level[CH_METER])
    );

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        dpwm_slicer #(.W(W)) u_slicer (
            .cnt_i   (cnt),
            .level_i (level[g]),
            .pwm_o   (pins[g])
        );
    end

    assign dac_pwm_o   = pins[CH_DAC];
    assign meter_pwm_o = pins[CH_METER];

    // R2: a pin only turns on at the start of a period
    a_r2_dac_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(dac_pwm_o) |-> (cnt == '0));

    a_r2_meter_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(meter_pwm_o) |-> (cnt == '0));

endmodule

// File: tb/dither_pwm_dac_tb.sv
`timescale 1ns/1ps
module dither_pwm_dac_tb;
    localparam int CLK_PERIOD = 100;
    localparam int SLOTS      = 256;

    logic              clk = 1'b0;
    logic              rst;
    logic [15:0]       dac_word;
    logic signed [7:0] err;
    logic              ref_seen;
    logic              dac_pwm;
    logic              meter_pwm;

    int vectors     = 0;
    int miscompares = 0;
    bit done        = 1'b0;

    int acc_m, exp_dac, exp_met;

    always #(CLK_PERIOD/2) clk = ~clk;

    dither_pwm_dac u_dut (
        .clk         (clk),
        .rst         (rst),
        .dac_word_i  (dac_word),
        .err_code_i  (err),
        .ref_seen_i  (ref_seen),
        .dac_pwm_o   (dac_pwm),
        .meter_pwm_o (meter_pwm)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        acc_m   = 0;
        exp_dac = 0;
        exp_met = 128;
    endtask

    // One period of 256 falling-edge samples starting at count 0.
    task automatic run_period(input logic [15:0] wa, input logic [15:0] wb,
                              input int sw, input int e, input bit seen,
                              input string dtag, input string mtag,
                              output int dsum);
        int dh = 0;
        int mh = 0;
        bit dlow = 0, mlow = 0, dbad = 0, mbad = 0;
        dac_word = wa;
        err      = 8'(e);
        ref_seen = seen;
        for (int i = 0; i < SLOTS; i++) begin
            if (i == sw) dac_word = wb;
            if (dac_pwm) begin dh++; if (dlow) dbad = 1; end else dlow = 1;
            if (meter_pwm) begin mh++; if (mlow) mbad = 1; end else mlow = 1;
            @(negedge clk);
        end
        chk(dtag, dh, exp_dac);
        chk(mtag, mh, exp_met);
        chk("R2 control pin single run from count 0", int'(dbad), 0);
        chk("R2 meter pin single run from count 0", int'(mbad), 0);
        dsum = dh;
        // Model: value at count 255 shapes the next period.
        acc_m   = acc_m + int'(wb[7:0]);
        exp_dac = int'(wb[15:8]) + (acc_m >> 8);
        acc_m   = acc_m & 255;
        exp_met = seen ? (e + 128) : 128;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int d, sum;
        bit full;
        logic [15:0] pats [10];
        pats = '{16'h0000, 16'h8000, 16'h00FF, 16'h8080, 16'h0001,
                 16'hFF00, 16'h7F40, 16'h0180, 16'hFE01, 16'h3C3C};
        rst = 1'b1; dac_word = '0; err = '0; ref_seen = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();

        // R1: first period after reset
        run_period(16'h0080, 16'h0080, SLOTS, 5, 0,
                   "R1 control pin low after reset", "R1 meter centred after reset", d);

        // R9: accumulator holds 0x80 here; reset mid-run must empty it
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        for (int k = 0; k < 4; k++)
            run_period(16'h0080, 16'h0080, SLOTS, 40, 0,
                       "R9 carry sequence restarts", "R8 meter centred", d);

        // R3 / R7: assorted words and error codes
        for (int p = 0; p < 10; p++)
            for (int k = 0; k < 2; k++)
                run_period(pats[p], pats[p], SLOTS, p * 25 - 120, 1,
                           "R3 whole plus carry", "R7 meter offset code", d);

        // R4: full-high period
        full = 0;
        for (int k = 0; k < 4; k++) begin
            run_period(16'hFFFF, 16'hFFFF, SLOTS, 127, 1,
                       "R4 top byte with carry", "R7 meter top code", d);
            if (d == SLOTS) full = 1;
        end
        chk("R4 saw a period high for all 256 clocks", int'(full), 1);

        // R5: mid-period changes do not touch the running period
        run_period(16'h4000, 16'hC000, 100, -128, 1,
                   "R5 mid-period change ignored", "R7 meter bottom code", d);
        run_period(16'hC000, 16'h2010, 255, 0, 1,
                   "R5 value at count 255 used", "R7 meter zero code", d);
        run_period(16'h2010, 16'h2010, SLOTS, 0, 1,
                   "R5 late change applied next", "R7 meter zero code", d);

        // R6 / R7: long average with meter sweep over every code
        run_period(16'h1237, 16'h1237, SLOTS, 0, 1, "R3 lead-in", "R7 lead-in", d);
        sum = 0;
        for (int p = 0; p < SLOTS; p++) begin
            run_period(16'h1237, 16'h1237, SLOTS, p - 128, 1,
                       "R3 constant word", "R7 meter sweep", d);
            sum += d;
        end
        chk("R6 average over 256 periods", sum, 256 * 8'h12 + 8'h37);

        // R6 / R8: all-ones word, meter held centred while codes sweep
        run_period(16'hFFFF, 16'hFFFF, SLOTS, 0, 0, "R3 lead-in", "R8 lead-in", d);
        sum = 0;
        for (int p = 0; p < SLOTS; p++) begin
            run_period(16'hFFFF, 16'hFFFF, SLOTS, p - 128, 0,
                       "R4 all-ones word", "R8 meter ignores code", d);
            sum += d;
        end
        chk("R6 all-ones average over 256 periods", sum, 65535);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule